// File: doc/BRIEF.md
# Paged Flash Write Window

This block gives a host a byte-wide window onto a serial flash with a 24-bit address space, one 256-byte page at a time. The host picks a page by writing two page-number registers, one for address bits 15:8 and one for bits 23:16. It then runs bursts on the window. A burst opens with a start pulse and closes with a stop pulse, and in between the host issues byte write strobes or byte read strobes. The same port also writes the page-number registers and a guard register, selected by a two-bit target code.

Writes to flash are locked after reset. To unlock them, the host writes a fixed six-byte code to the guard register. Writing zero to the guard register locks them again. A write burst starts with an offset byte, which must be zero, and the data bytes follow it. The data bytes fill a page buffer starting at byte 0. If the burst is accepted, the stop pulse raises a one-cycle program request that carries the page base address and the byte count. The block then stays busy until the flash side acknowledges the request. While busy, the flash side reads the buffer through an index port. Each read strobe in a read burst fetches one byte from the flash side through a request and acknowledge handshake. The fetches run in order from byte 0 of the selected page, and every start pulse brings the position back to byte 0.

Top module: `pgwin_top`

## Requirements
- R1: After reset, wr_unlocked, err_flag, busy, prog_req, fetch_req and bus_rvalid are all 0.
- R2: A register write with bus_sel=1 loads page address bits 15:8, and one with bus_sel=2 loads bits 23:16. prog_addr and fetch_addr carry these bits, and prog_addr bits 7:0 are always 0.
- R3: Guard writes (bus_sel=3) of 0xAA, 0x55, 0x50, 0x41, 0x52, 0x44 in exactly that order set wr_unlocked to 1. A shorter prefix of the code leaves it at 0.
- R4: A guard byte that does not match the next expected code byte sends the detector back to its start. If that byte is 0xAA, it counts as the first byte of a new attempt.
- R5: A guard write of 0x00 clears wr_unlocked.
- R6: In an accepted write burst on the window (bus_sel=0), the offset byte 0 comes first and the data bytes follow, stored from index 0 upward. On stop, prog_req is 1 for exactly one cycle with prog_addr set to the page base and prog_count set to the number of data bytes. busy stays 1 from that cycle until a cycle with prog_ack=1.
- R7: Buffer bytes that were not written in the last accepted burst read back as 0xFF on prog_data.
- R8: A write burst is discarded if its offset byte is nonzero, if the window is locked, or if busy is 1. A discarded burst raises no request, leaves the buffer unchanged, and sets err_flag, which then stays 1 until reset.
- R9: A write burst with more than 256 data bytes is discarded and sets err_flag. A burst of exactly 256 bytes is accepted with prog_count=256.
- R10: Each read strobe fetches the next consecutive byte of the selected page, starting at byte 0 after every start pulse. The byte comes back on bus_rdata together with a one-cycle bus_rvalid.
- R11: A read strobe after 256 bytes have been read in one burst raises no fetch, returns 0xFF with bus_rvalid, and sets err_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Opens a window burst |
| bus_stop | input | 1 | Closes a window burst |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_sel | input | 2 | Target: 0 window, 1 page bits 15:8, 2 page bits 23:16, 3 guard |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte |
| bus_rvalid | output | 1 | One-cycle marker that bus_rdata is valid |
| wr_unlocked | output | 1 | Flash writes enabled |
| err_flag | output | 1 | Sticky error for rejected transfers |
| busy | output | 1 | Program request outstanding |
| prog_req | output | 1 | One-cycle page-program request |
| prog_addr | output | 24 | Page base address of the request |
| prog_count | output | 9 | Number of data bytes in the request |
| prog_ack | input | 1 | Program done, releases busy |
| prog_idx | input | 8 | Buffer index read by the flash side |
| prog_data | output | 8 | Buffer byte at prog_idx |
| fetch_req | output | 1 | Read fetch request, held until acknowledged |
| fetch_addr | output | 24 | Flash address of the fetch |
| fetch_ack | input | 1 | Fetch data valid |
| fetch_data | input | 8 | Fetched byte |

## Verification
A detector stuck in the wrong step shows up on wr_unlocked in the cycle after the sixth guard byte, or after a breaking byte followed by a fresh code. A count that is off by one or a wrong overflow bound shows up on prog_count, or as a missing prog_req, in the cycle after stop. A fill marker that is never cleared makes prog_data read 0xFF, or a stale byte, at an index the bench checks right after the request. A read position that does not go back to 0 on start returns the wrong fetched byte on the first bus_rvalid. A flag that loses its sticky state drops err_flag at a later check.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned UNLOCK_LEN = 6;

  typedef enum logic [1:0] {
    SEL_WIN   = 2'd0,
    SEL_PGLO  = 2'd1,
    SEL_PGHI  = 2'd2,
    SEL_GUARD = 2'd3
  } sel_e;

  function automatic logic [BYTE_W-1:0] unlock_byte(input logic [2:0] k);
    logic [BYTE_W-1:0] b;
    case (k)
      3'd0:    b = 8'hAA;
      3'd1:    b = 8'h55;
      3'd2:    b = 8'h50;
      3'd3:    b = 8'h41;
      3'd4:    b = 8'h52;
      default: b = 8'h44;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/pgwin_unlock.sv
module pgwin_unlock
  import pgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              unlocked
);
  localparam logic [2:0] DONE = 3'(UNLOCK_LEN);

  logic [2:0] step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (wr_en) begin
      if (wr_data == '0)
        step_d = '0;
      else if (step_q == DONE)
        step_d = DONE;
      else if (wr_data == unlock_byte(step_q))
        step_d = step_q + 3'd1;
      else if (wr_data == unlock_byte(3'd0))
        step_d = 3'd1;
      else
        step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_q <= '0;
    else if (wr_en) step_q <= step_d;
  end

  assign unlocked = (step_q == DONE);
endmodule

// File: rtl/pgwin_pagebuf.sv
module pgwin_pagebuf
  import pgwin_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  fill_q, fill_d;

  always_comb begin
    fill_d = fill_q;
    if (clr)     fill_d = '0;
    else if (we) fill_d[widx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fill_q <= '0;
    else if (clr || we) fill_q <= fill_d;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = fill_q[ridx] ? mem[ridx] : '1;
endmodule

// File: rtl/pgwin_wrctl.sv
module pgwin_wrctl
  import pgwin_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PG_W  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              unlocked,
  input  logic [PG_W-1:0]   page_base,
  input  logic              prog_ack,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_widx,
  output logic              busy,
  output logic              prog_req,
  output logic [PG_W+IDX_W-1:0] prog_addr,
  output logic [CNT_W-1:0]  prog_count,
  output logic              err_set
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic in_q, in_d, off_q, off_d, bad_q, bad_d;
  logic busy_q, busy_d, req_q, req_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pcnt_q, pcnt_d;
  logic [PG_W-1:0]  pbase_q, pbase_d;
  logic issue;

  always_comb begin
    in_d = in_q; off_d = off_q; bad_d = bad_q; cnt_d = cnt_q;
    busy_d = busy_q; pcnt_d = pcnt_q; pbase_d = pbase_q;
    buf_clr = 1'b0; buf_we = 1'b0; err_set = 1'b0; issue = 1'b0;
    if (busy_q && prog_ack) busy_d = 1'b0;
    if (start) begin
      in_d = 1'b1; off_d = 1'b0; bad_d = 1'b0; cnt_d = '0;
    end else if (wr_en && in_q) begin
      if (!off_q) begin
        off_d = 1'b1;
        if (wdata != '0 || !unlocked || busy_q) bad_d = 1'b1;
        else                                   buf_clr = 1'b1;
      end else if (!bad_q) begin
        if (cnt_q == FULL) bad_d = 1'b1;
        else begin
          buf_we = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
    end else if (stop && in_q) begin
      in_d = 1'b0;
      if (off_q && bad_q) err_set = 1'b1;
      else if (off_q && cnt_q != '0) begin
        issue   = 1'b1;
        busy_d  = 1'b1;
        pcnt_d  = cnt_q;
        pbase_d = page_base;
      end
    end
    req_d = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0; off_q <= 1'b0; bad_q <= 1'b0; cnt_q <= '0;
      busy_q <= 1'b0; req_q <= 1'b0; pcnt_q <= '0; pbase_q <= '0;
    end else begin
      in_q <= in_d; off_q <= off_d; bad_q <= bad_d; cnt_q <= cnt_d;
      busy_q <= busy_d; req_q <= req_d;
      if (issue) begin
        pcnt_q  <= pcnt_d;
        pbase_q <= pbase_d;
      end
    end
  end

  assign buf_widx   = cnt_q[IDX_W-1:0];
  assign busy       = busy_q;
  assign prog_req   = req_q;
  assign prog_addr  = {pbase_q, {IDX_W{1'b0}}};
  assign prog_count = pcnt_q;
endmodule

// File: rtl/pgwin_rdctl.sv
module pgwin_rdctl
  import pgwin_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PG_W  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_en,
  input  logic [PG_W-1:0]   page_base,
  input  logic              fetch_ack,
  input  logic [BYTE_W-1:0] fetch_data,
  output logic              fetch_req,
  output logic [PG_W+IDX_W-1:0] fetch_addr,
  output logic [BYTE_W-1:0] rdata,
  output logic              rvalid,
  output logic              err_set
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic req_q, req_d, vld_d, vld_q;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic [PG_W+IDX_W-1:0] adr_q, adr_d;

  always_comb begin
    pos_d = pos_q; req_d = req_q; dat_d = dat_q; adr_d = adr_q;
    vld_d = 1'b0; err_set = 1'b0;
    if (req_q) begin
      if (fetch_ack) begin
        req_d = 1'b0;
        dat_d = fetch_data;
        vld_d = 1'b1;
        pos_d = pos_q + 1'b1;
      end
    end else if (start) begin
      pos_d = '0;
    end else if (rd_en) begin
      if (pos_q == FULL) begin
        dat_d   = '1;
        vld_d   = 1'b1;
        err_set = 1'b1;
      end else begin
        req_d = 1'b1;
        adr_d = {page_base, pos_q[IDX_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0; req_q <= 1'b0; vld_q <= 1'b0; dat_q <= '0; adr_q <= '0;
    end else begin
      pos_q <= pos_d; req_q <= req_d; vld_q <= vld_d;
      if (vld_d)             dat_q <= dat_d;
      if (req_d && !req_q)   adr_q <= adr_d;
    end
  end

  assign fetch_req  = req_q;
  assign fetch_addr = adr_q;
  assign rdata      = dat_q;
  assign rvalid     = vld_q;
endmodule

// File: rtl/pgwin_top.sv
module pgwin_top
  import pgwin_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned IDX_W  = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W  = IDX_W + 1,
  localparam int unsigned PG_N   = 2,
  localparam int unsigned PG_W   = PG_N * BYTE_W,
  localparam int unsigned ADDR_W = PG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              wr_unlocked,
  output logic              err_flag,
  output logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [CNT_W-1:0]  prog_count,
  input  logic              prog_ack,
  input  logic [IDX_W-1:0]  prog_idx,
  output logic [BYTE_W-1:0] prog_data,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [BYTE_W-1:0] fetch_data
);
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic win_wr, win_rd, guard_wr;
  assign win_wr   = bus_wr && (bus_sel == SEL_WIN);
  assign win_rd   = bus_rd && (bus_sel == SEL_WIN);
  assign guard_wr = bus_wr && (bus_sel == SEL_GUARD);

  logic [PG_W-1:0] page_base;

  for (genvar g = 0; g < PG_N; g++) begin : g_page
    logic              ld;
    logic [BYTE_W-1:0] pg_q;
    assign ld = bus_wr && (bus_sel == 2'(int'(SEL_PGLO) + g));
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) pg_q <= '0;
      else if (ld)  pg_q <= bus_wdata;
    end
    assign page_base[g*BYTE_W +: BYTE_W] = pg_q;
  end

  pgwin_unlock u_unlock (
    .clk(clk), .rst_n(rst_s_n), .wr_en(guard_wr), .wr_data(bus_wdata),
    .unlocked(wr_unlocked)
  );

  logic             buf_clr, buf_we, wr_err, rd_err;
  logic [IDX_W-1:0] buf_widx;

  pgwin_wrctl #(.DEPTH(PAGE_BYTES), .PG_W(PG_W)) u_wrctl (
    .clk(clk), .rst_n(rst_s_n), .start(bus_start), .stop(bus_stop),
    .wr_en(win_wr), .wdata(bus_wdata), .unlocked(wr_unlocked),
    .page_base(page_base), .prog_ack(prog_ack), .buf_clr(buf_clr),
    .buf_we(buf_we), .buf_widx(buf_widx), .busy(busy), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_count(prog_count), .err_set(wr_err)
  );

  pgwin_pagebuf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_s_n), .clr(buf_clr), .we(buf_we), .widx(buf_widx),
    .wdata(bus_wdata), .ridx(prog_idx), .rdata(prog_data)
  );

  pgwin_rdctl #(.DEPTH(PAGE_BYTES), .PG_W(PG_W)) u_rdctl (
    .clk(clk), .rst_n(rst_s_n), .start(bus_start), .rd_en(win_rd),
    .page_base(page_base), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .rdata(bus_rdata),
    .rvalid(bus_rvalid), .err_set(rd_err)
  );

  logic err_q, err_d;
  always_comb err_d = err_q || wr_err || rd_err;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end
  assign err_flag = err_q;
endmodule

// File: rtl/pgwin_chk.sv
module pgwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_sel,
  input logic [7:0]  bus_wdata,
  input logic        wr_unlocked,
  input logic        err_flag,
  input logic        busy,
  input logic        prog_req,
  input logic        prog_ack,
  input logic [23:0] prog_addr,
  input logic [8:0]  prog_count,
  input logic        fetch_req,
  input logic        fetch_ack,
  input logic [23:0] fetch_addr
);
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_ack) |=> busy);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (prog_addr[7:0] == 8'h00));
  p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (prog_count != 9'd0 && prog_count <= 9'd256));
  p_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd3 && bus_wdata == 8'h00) |=> !wr_unlocked);
endmodule

bind pgwin_top pgwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .wr_unlocked(wr_unlocked), .err_flag(err_flag),
  .busy(busy), .prog_req(prog_req), .prog_ack(prog_ack),
  .prog_addr(prog_addr), .prog_count(prog_count), .fetch_req(fetch_req),
  .fetch_ack(fetch_ack), .fetch_addr(fetch_addr)
);

// File: tb/pgwin_top_tb_top.sv
module pgwin_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 1'b0, bus_stop = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bus_rvalid, wr_unlocked, err_flag, busy, prog_req;
  logic [23:0] prog_addr;
  logic [8:0] prog_count;
  logic prog_ack = 1'b0;
  logic [7:0] prog_idx = 8'h00;
  logic [7:0] prog_data;
  logic fetch_req;
  logic [23:0] fetch_addr;
  logic fetch_ack = 1'b0;
  logic [7:0] fetch_data = 8'h00;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .wr_unlocked(wr_unlocked),
    .err_flag(err_flag), .busy(busy), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_count(prog_count), .prog_ack(prog_ack),
    .prog_idx(prog_idx), .prog_data(prog_data), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data)
  );

  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 5);
  endfunction

  // flash-side fetch responder
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_req && !fetch_ack) begin
        fetch_ack  = 1'b1;
        fetch_data = flash_byte(fetch_addr);
      end else begin
        fetch_ack = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    bus_sel = 2'd0; bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic unlock();
    reg_write(2'd3, 8'hAA); reg_write(2'd3, 8'h55); reg_write(2'd3, 8'h50);
    reg_write(2'd3, 8'h41); reg_write(2'd3, 8'h52); reg_write(2'd3, 8'h44);
  endtask

  task automatic write_burst(input logic [7:0] off, input int n, input logic [7:0] seed);
    pulse_start();
    reg_write(2'd0, off);
    for (int i = 0; i < n; i++) reg_write(2'd0, pat(seed, i));
    pulse_stop();
  endtask

  task automatic read_byte(output logic [7:0] d, output bit got);
    @(negedge clk);
    bus_sel = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (bus_rvalid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    d = bus_rdata;
  endtask

  task automatic ack_prog();
    @(negedge clk);
    prog_ack = 1'b1;
    @(negedge clk);
    prog_ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!wr_unlocked && !err_flag && !busy, "R1 status", {wr_unlocked, err_flag, busy}, 0);
    chk(!prog_req && !fetch_req && !bus_rvalid, "R1 requests", {prog_req, fetch_req, bus_rvalid}, 0);
  endtask

  task automatic t_unlock();
    do_reset();
    reg_write(2'd3, 8'hAA); reg_write(2'd3, 8'h55); reg_write(2'd3, 8'h50);
    reg_write(2'd3, 8'h41); reg_write(2'd3, 8'h52);
    chk(!wr_unlocked, "R3 prefix stays locked", wr_unlocked, 0);
    reg_write(2'd3, 8'h44);
    chk(wr_unlocked, "R3 full code unlocks", wr_unlocked, 1);
    reg_write(2'd3, 8'h00);
    chk(!wr_unlocked, "R5 zero relocks", wr_unlocked, 0);
    reg_write(2'd3, 8'hAA); reg_write(2'd3, 8'h55); reg_write(2'd3, 8'h12);
    reg_write(2'd3, 8'h50); reg_write(2'd3, 8'h41); reg_write(2'd3, 8'h52);
    reg_write(2'd3, 8'h44);
    chk(!wr_unlocked, "R4 broken code stays locked", wr_unlocked, 0);
    reg_write(2'd3, 8'hAA); reg_write(2'd3, 8'h55); reg_write(2'd3, 8'hAA);
    reg_write(2'd3, 8'h55); reg_write(2'd3, 8'h50); reg_write(2'd3, 8'h41);
    reg_write(2'd3, 8'h52); reg_write(2'd3, 8'h44);
    chk(wr_unlocked, "R4 0xAA restarts attempt", wr_unlocked, 1);
  endtask

  task automatic t_write_short();
    do_reset();
    reg_write(2'd1, 8'h34); reg_write(2'd2, 8'h12);
    unlock();
    write_burst(8'h00, 3, 8'h21);
    chk(prog_req, "R6 request raised", prog_req, 1);
    chk(prog_addr == 24'h123400, "R2 page base", prog_addr, 24'h123400);
    chk(prog_count == 9'd3, "R6 byte count", prog_count, 3);
    @(negedge clk);
    chk(!prog_req && busy, "R6 single pulse then busy", {prog_req, busy}, 1);
    for (int i = 0; i < 3; i++) begin
      prog_idx = 8'(i); #1;
      chk(prog_data == pat(8'h21, i), "R6 buffered byte", prog_data, pat(8'h21, i));
    end
    prog_idx = 8'd3; #1;
    chk(prog_data == 8'hFF, "R7 unwritten idx3", prog_data, 8'hFF);
    prog_idx = 8'd255; #1;
    chk(prog_data == 8'hFF, "R7 unwritten idx255", prog_data, 8'hFF);
    repeat (3) @(negedge clk);
    chk(busy, "R6 busy held until ack", busy, 1);
    // write while busy is discarded
    write_burst(8'h00, 2, 8'h90);
    chk(!prog_req, "R8 busy burst no request", prog_req, 0);
    chk(err_flag, "R8 busy burst error", err_flag, 1);
    prog_idx = 8'd0; #1;
    chk(prog_data == pat(8'h21, 0), "R8 buffer unchanged", prog_data, pat(8'h21, 0));
    ack_prog();
    chk(!busy, "R6 ack releases busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(err_flag, "R8 error sticky", err_flag, 1);
  endtask

  task automatic t_rejects();
    do_reset();
    write_burst(8'h00, 2, 8'h10);
    chk(!prog_req && err_flag, "R8 locked burst rejected", {prog_req, err_flag}, 1);
    do_reset();
    unlock();
    write_burst(8'h05, 2, 8'h10);
    chk(!prog_req && err_flag, "R8 nonzero offset rejected", {prog_req, err_flag}, 1);
    chk(!busy, "R8 no busy after reject", busy, 0);
  endtask

  task automatic t_full();
    do_reset();
    reg_write(2'd1, 8'h00); reg_write(2'd2, 8'h7F);
    unlock();
    write_burst(8'h00, 256, 8'h03);
    chk(prog_req && prog_count == 9'd256, "R9 full page accepted", prog_count, 256);
    chk(prog_addr == 24'h7F0000, "R2 high page byte", prog_addr, 24'h7F0000);
    prog_idx = 8'd255; #1;
    chk(prog_data == pat(8'h03, 255), "R9 last byte", prog_data, pat(8'h03, 255));
    chk(!err_flag, "R9 no error on full page", err_flag, 0);
    ack_prog();
    write_burst(8'h00, 257, 8'h03);
    chk(!prog_req && err_flag, "R9 overlong rejected", {prog_req, err_flag}, 1);
  endtask

  task automatic t_read();
    logic [7:0] d;
    bit got;
    do_reset();
    reg_write(2'd1, 8'h0A); reg_write(2'd2, 8'hC3);
    pulse_start();
    for (int i = 0; i < 3; i++) begin
      read_byte(d, got);
      chk(got && d == flash_byte(24'hC30A00 + 24'(i)), "R10 consecutive read", d,
          flash_byte(24'hC30A00 + 24'(i)));
    end
    pulse_stop();
    pulse_start();
    read_byte(d, got);
    chk(got && d == flash_byte(24'hC30A00), "R10 start restarts at 0", d,
        flash_byte(24'hC30A00));
    pulse_start();
    for (int i = 0; i < 256; i++) begin
      read_byte(d, got);
      if (!got || d != flash_byte(24'hC30A00 + 24'(i)))
        chk(1'b0, "R10 page read", d, flash_byte(24'hC30A00 + 24'(i)));
    end
    chk(!err_flag, "R10 full page read clean", err_flag, 0);
    read_byte(d, got);
    chk(got && d == 8'hFF, "R11 beyond page 0xFF", d, 8'hFF);
    chk(!fetch_req, "R11 no fetch beyond page", fetch_req, 0);
    @(negedge clk);
    chk(err_flag, "R11 error set", err_flag, 1);
    pulse_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unlock();
    t_write_short();
    t_rejects();
    t_full();
    t_read();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule